// File: doc/BRIEF.md
# Bit-Field ALU

This block is the purely combinational arithmetic and logic unit of a small 32-bit RISC core. The core's decode stage supplies operand A, operand B and a 4-bit operation code. Operand B is either a register value or a sign-extended 10-bit immediate, and that choice is made before this block. The block returns a 32-bit result in the same cycle.

Beside the usual add, subtract, logic and shift operations, the unit provides several less common ones:
- a rotate right;
- an append-immediate operation that shifts A left by ten places and fills the gap with the low ten bits of B;
- insertion of a bit field;
- signed and unsigned extraction of a bit field;
- a five-stage conditional swap network that permutes the bits of A.

For the field operations, operand B carries both the field geometry and, for insertion, the data to insert. Code 15 has no defined operation and raises the illegal flag. Flag generation, operand selection and the register file live elsewhere.

Top module: `bfalu_core`

## Requirements
- R1: Code 0 returns A+B and code 2 returns A−B, both modulo 2^32.
- R2: Code 1 rotates A right by B[4:0] places. The bits of B above bit 4 are ignored.
- R3: Code 3 returns (A shifted left by 10) OR (B AND 0x3FF). The upper ten bits of A are lost.
- R4: Code 4 returns A AND B, code 5 returns A OR B, code 6 returns A XOR B, and code 7 returns NOT(A XOR B).
- R5: Code 8 shifts A left, code 9 shifts A right logically and code 10 shifts A right arithmetically. Each shift uses only B[4:0] as the shift amount, so an amount of 32 or more acts modulo 32.
- R6: For codes 11, 12 and 13, the field position is B[4:0] and the field length is B[8:5]. A length value of 0 selects a length of 16.
- R7: Code 11 replaces bits pos to pos+len−1 of A with the low len bits of (B shifted right by 10). All other bits of A are kept. Field bits that would lie above bit 31 are dropped.
- R8: Code 12 takes (A logically shifted right by pos), keeps its low len bits and sign-extends them from bit len−1. Code 13 does the same but zero-extends.
- R9: Code 14 processes A through five stages in this order, each enabled by one bit of B:
  - B[0] swaps adjacent bits;
  - B[1] swaps adjacent 2-bit groups;
  - B[2] swaps nibbles;
  - B[3] swaps bytes;
  - B[4] swaps halfwords.
- R10: Code 15 sets the illegal output to 1 and drives the result to 0. Every other code drives the illegal output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B: a register value or an immediate, selected upstream |
| op_code | input | 4 | Operation code |
| result | output | 32 | Operation result |
| illegal | output | 1 | High for the undefined operation code |

## Verification
The field operations are tried with three geometries:
- a field in the middle of the word;
- a zero length field, which tells the 16-bit default apart from an empty field;
- a field at position 30, which shows whether bits past bit 31 are dropped or wrap around.

Signed and unsigned extraction are given the same field with its top bit set and clear, which separates sign extension from zero extension. The swap network is tried with single stages and with all five stages together; the full set must reverse the word. Shift and rotate amounts of 32 or more show whether B[4:0] is used alone. A pseudo-random sweep over every code then compares the unit against a model of the same rules.

// File: rtl/bfalu_pkg.sv
package bfalu_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ROR  = 4'h1,
    OP_SUB  = 4'h2,
    OP_APP  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_XNOR = 4'h7,
    OP_SLL  = 4'h8,
    OP_SRL  = 4'h9,
    OP_SRA  = 4'hA,
    OP_INS  = 4'hB,
    OP_EXS  = 4'hC,
    OP_EXU  = 4'hD,
    OP_PERM = 4'hE,
    OP_RSVD = 4'hF
  } alu_op_e;

endpackage

// File: rtl/bfalu_shift.sv
module bfalu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] ror_res,
  output logic [DATA_W-1:0] sll_res,
  output logic [DATA_W-1:0] srl_res,
  output logic [DATA_W-1:0] sra_res
);

  logic [2*DATA_W-1:0] doubled;
  logic [2*DATA_W-1:0] doubled_sh;

  always_comb begin
    doubled    = {a, a};
    doubled_sh = doubled >> amt;
    ror_res    = doubled_sh[DATA_W-1:0];
    sll_res    = a << amt;
    srl_res    = a >> amt;
    sra_res    = DATA_W'($signed(a) >>> amt);
  end

  always_comb begin
    if (!$isunknown({a, amt})) begin
      // R2
      ror_popcount_chk: assert ($countones(ror_res) == $countones(a));
      // R5
      shift_agree_chk: assert (((sra_res ^ srl_res) == '0) || a[DATA_W-1]);
    end
  end

endmodule

// File: rtl/bfalu_field.sv
module bfalu_field #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4,
  parameter int INS_SHIFT = 10,
  localparam int POS_W = $clog2(DATA_W),
  localparam int DEF_LEN = 1 << LEN_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] ins_res,
  output logic [DATA_W-1:0] exs_res,
  output logic [DATA_W-1:0] exu_res
);

  logic [POS_W-1:0]  pos;
  logic [LEN_W-1:0]  len_raw;
  logic [LEN_W:0]    eff_len;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] top_bit;
  logic [DATA_W-1:0] place_mask;
  logic [DATA_W-1:0] ins_data;
  logic [DATA_W-1:0] extracted;
  logic              sign_bit;

  always_comb begin
    pos        = b[POS_W-1:0];
    len_raw    = b[POS_W+LEN_W-1:POS_W];
    eff_len    = (len_raw == '0) ? (LEN_W+1)'(DEF_LEN) : {1'b0, len_raw};
    low_mask   = (DATA_W'(1) << eff_len) - DATA_W'(1);
    top_bit    = low_mask ^ (low_mask >> 1);
    place_mask = low_mask << pos;
    ins_data   = (b >> INS_SHIFT) << pos;
    ins_res    = (a & ~place_mask) | (ins_data & place_mask);
    extracted  = (a >> pos) & low_mask;
    sign_bit   = |(extracted & top_bit);
    exu_res    = extracted;
    exs_res    = sign_bit ? (extracted | ~low_mask) : extracted;
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R7
      ins_keep_chk: assert (((ins_res ^ a) & ~place_mask) == '0);
      // R8
      ext_low_agree_chk: assert (((exs_res ^ exu_res) & low_mask) == '0);
      // R6
      len_range_chk: assert (eff_len != '0 && eff_len <= (LEN_W+1)'(DEF_LEN));
    end
  end

endmodule

// File: rtl/bfalu_permute.sv
module bfalu_permute #(
  parameter int DATA_W = 32,
  localparam int STAGES = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [STAGES-1:0] ctl,
  output logic [DATA_W-1:0] perm_res
);

  logic [DATA_W-1:0] stage_val [STAGES+1];

  assign stage_val[0] = a;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign stage_val[k+1][i] = ctl[k] ? stage_val[k][i ^ (1 << k)] : stage_val[k][i];
    end
  end

  assign perm_res = stage_val[STAGES];

  always_comb begin
    if (!$isunknown({a, ctl})) begin
      // R9
      perm_popcount_chk: assert ($countones(perm_res) == $countones(a));
      // R9
      perm_idle_chk: assert ((ctl != '0) || (perm_res == a));
    end
  end

endmodule

// File: rtl/bfalu_core.sv
module bfalu_core
  import bfalu_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int APP_W = 10,
  parameter int FIELD_LEN_W = 4,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_code,
  output logic [W-1:0] result,
  output logic         illegal
);

  logic [W-1:0] ror_res, sll_res, srl_res, sra_res;
  logic [W-1:0] ins_res, exs_res, exu_res;
  logic [W-1:0] perm_res;
  logic [W-1:0] app_res;
  alu_op_e      op;

  bfalu_shift #(.DATA_W(W)) u_shift (
    .a       (op_a),
    .amt     (op_b[SH_W-1:0]),
    .ror_res (ror_res),
    .sll_res (sll_res),
    .srl_res (srl_res),
    .sra_res (sra_res)
  );

  bfalu_field #(.DATA_W(W), .LEN_W(FIELD_LEN_W), .INS_SHIFT(APP_W)) u_field (
    .a       (op_a),
    .b       (op_b),
    .ins_res (ins_res),
    .exs_res (exs_res),
    .exu_res (exu_res)
  );

  bfalu_permute #(.DATA_W(W)) u_perm (
    .a        (op_a),
    .ctl      (op_b[SH_W-1:0]),
    .perm_res (perm_res)
  );

  always_comb begin
    op      = alu_op_e'(op_code);
    app_res = (op_a << APP_W) | (op_b & W'((1 << APP_W) - 1));
    illegal = 1'b0;
    result  = '0;
    case (op)
      OP_ADD:  result = op_a + op_b;
      OP_ROR:  result = ror_res;
      OP_SUB:  result = op_a - op_b;
      OP_APP:  result = app_res;
      OP_AND:  result = op_a & op_b;
      OP_OR:   result = op_a | op_b;
      OP_XOR:  result = op_a ^ op_b;
      OP_XNOR: result = ~(op_a ^ op_b);
      OP_SLL:  result = sll_res;
      OP_SRL:  result = srl_res;
      OP_SRA:  result = sra_res;
      OP_INS:  result = ins_res;
      OP_EXS:  result = exs_res;
      OP_EXU:  result = exu_res;
      OP_PERM: result = perm_res;
      default: illegal = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_code, op_a, op_b})) begin
      // R10
      illegal_code_chk: assert (illegal == (op_code == 4'hF));
      // R10
      illegal_zero_chk: assert (!illegal || result == '0);
      // R1
      addsub_inverse_chk: assert ((op_code != 4'h0) || (result - op_b == op_a));
    end
  end

endmodule

// File: tb/tb_bfalu_core.sv
module tb_bfalu_core;

  logic        clk;
  logic [31:0] op_a, op_b, result;
  logic [3:0]  op_code;
  logic        illegal;
  int          n_checks;
  int          n_fail;
  int          cycles;
  bit          done;

  bfalu_core dut (
    .op_a    (op_a),
    .op_b    (op_b),
    .op_code (op_code),
    .result  (result),
    .illegal (illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam int NV = 23;
  // {op, a, b, expected result, expected illegal}
  localparam logic [100:0] VEC [NV] = '{
    {4'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    {4'h2, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0},
    {4'h1, 32'h00000001, 32'h00000021, 32'h80000000, 1'b0},
    {4'h3, 32'h00000001, 32'hFFFFFFFF, 32'h000007FF, 1'b0},
    {4'h4, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0},
    {4'h5, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0},
    {4'h6, 32'hAAAAAAAA, 32'hFFFF0000, 32'h5555AAAA, 1'b0},
    {4'h7, 32'h12345678, 32'h12345678, 32'hFFFFFFFF, 1'b0},
    {4'h8, 32'h00000001, 32'h00000024, 32'h00000010, 1'b0},
    {4'h9, 32'h80000000, 32'h0000001F, 32'h00000001, 1'b0},
    {4'hA, 32'h80000000, 32'h00000004, 32'hF8000000, 1'b0},
    {4'hB, 32'h00000000, 32'h00003C88, 32'h00000F00, 1'b0},
    {4'hB, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0000, 1'b0},
    {4'hB, 32'h00000000, 32'h00003C9E, 32'hC0000000, 1'b0},
    {4'hC, 32'h00000F00, 32'h00000088, 32'hFFFFFFFF, 1'b0},
    {4'hD, 32'h00000F00, 32'h00000088, 32'h0000000F, 1'b0},
    {4'hC, 32'h00008001, 32'h00000000, 32'hFFFF8001, 1'b0},
    {4'hC, 32'h00000700, 32'h00000088, 32'h00000007, 1'b0},
    {4'hE, 32'h00000001, 32'h00000001, 32'h00000002, 1'b0},
    {4'hE, 32'h00000001, 32'h0000001F, 32'h80000000, 1'b0},
    {4'hE, 32'h12345678, 32'h00000010, 32'h56781234, 1'b0},
    {4'hE, 32'h12345678, 32'h00000008, 32'h34127856, 1'b0},
    {4'hF, 32'h12345678, 32'h9ABCDEF0, 32'h00000000, 1'b1}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'h0, 4'h2:             return "R1";
      4'h1:                   return "R2";
      4'h3:                   return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9, 4'hA:       return "R5";
      4'hB:                   return "R7";
      4'hC, 4'hD:             return "R8";
      4'hE:                   return "R9";
      default:                return "R10";
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [31:0] r, m, f, x;
    int sh, pos, len;
    sh  = int'(b[4:0]);
    pos = int'(b[4:0]);
    len = (b[8:5] == 4'd0) ? 16 : int'(b[8:5]);
    m = 32'h0;
    for (int i = 0; i < len; i++) m[i] = 1'b1;
    r = 32'h0;
    case (op)
      4'h0: r = a + b;
      4'h1: r = (sh == 0) ? a : ((a >> sh) | (a << (32 - sh)));
      4'h2: r = a - b;
      4'h3: r = {a[21:0], b[9:0]};
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a ^ b);
      4'h8: r = a << sh;
      4'h9: r = a >> sh;
      4'hA: r = $signed(a) >>> sh;
      4'hB: begin
        r = a;
        f = b >> 10;
        for (int i = 0; i < len; i++)
          if (pos + i < 32) r[pos + i] = f[i];
      end
      4'hC, 4'hD: begin
        r = (a >> pos) & m;
        if (op == 4'hC && r[len - 1])
          r = r | ~m;
      end
      4'hE: begin
        x = a;
        for (int k = 0; k < 5; k++) begin
          if (b[k]) begin
            f = x;
            for (int i = 0; i < 32; i++) x[i] = f[i ^ (1 << k)];
          end
        end
        r = x;
      end
      default: return {1'b1, 32'h0};
    endcase
    return {1'b0, r};
  endfunction

  task automatic apply_check(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] exp_r, input logic exp_i, input string req);
    @(posedge clk);
    op_code = op;
    op_a    = a;
    op_b    = b;
    @(negedge clk);
    n_checks++;
    if (result !== exp_r || illegal !== exp_i) begin
      n_fail++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h/%b expected=%h/%b",
               req, op, a, b, result, illegal, exp_r, exp_i);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] seed, ra, rb;
    logic [32:0] mv;
    n_checks = 0;
    n_fail   = 0;
    cycles   = 0;
    done     = 1'b0;
    op_code  = 4'h0;
    op_a     = 32'h0;
    op_b     = 32'h0;
    // Quiet state: add of zeros gives zero, not illegal (R1, R10)
    apply_check(4'h0, 32'h0, 32'h0, 32'h0, 1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      apply_check(VEC[v][100:97], VEC[v][96:65], VEC[v][64:33], VEC[v][32:1], VEC[v][0],
                  req_of(VEC[v][100:97]));
    end

    // R6: length value 0 means 16 for unsigned extract at pos 4
    apply_check(4'hD, 32'hFFFFFFFF, 32'h00000004, 32'h0000FFFF, 1'b0, "R6");
    // R6: length 15 at pos 0, B bits above 8 ignored
    apply_check(4'hD, 32'hFFFFFFFF, 32'hFFFFFDE0, 32'h00007FFF, 1'b0, "R6");
    // R2: upper bits of B ignored for rotate
    apply_check(4'h1, 32'h000000F0, 32'hFFFFFFE4, 32'h0000000F, 1'b0, "R2");
    // R5: shift by 32 acts as 0
    apply_check(4'h8, 32'h12345678, 32'h00000020, 32'h12345678, 1'b0, "R5");
    // R9: no stage enabled leaves A
    apply_check(4'hE, 32'hDEADBEEF, 32'hFFFFFFE0, 32'hDEADBEEF, 1'b0, "R9");
    // R10: illegal with other operands
    apply_check(4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b1, "R10");

    seed = 32'h1ACE5EED;
    for (int n = 0; n < 64; n++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = seed;
      for (int op = 0; op < 16; op++) begin
        mv = model(4'(op), ra, rb);
        apply_check(4'(op), ra, rb, mv[31:0], mv[32], req_of(4'(op)));
      end
    end

    done = 1'b1;
    finish_run();
  end

endmodule